// File: doc/BRIEF.md
# Timer Bank Register Front End

This block sits between a simple 32-bit register bus and a bank of eight counting channels. Each bus access is decoded into a per-channel register strobe or into one of two shared control words. The per-channel registers are held in small stub channels that are instantiated inside the block. Three low channels share a region at the bottom of the map. The shared control word, a spare word and then five more channels follow in that order. Any other offset, and any access that is not aligned to 32 bits, is rejected.

The shared control word carries four configuration bits for every channel. When it is written, the block applies the new bits in a safe order. A channel that is being switched off stops in the first cycle, together with its configuration change. A channel that is being switched on starts one cycle later, after its new configuration has already taken effect. Start, stop and configuration-update pulses fire only for bits that really change. Pulse mode is accepted only on the upper four channels. Asking for it on a lower channel leaves the bit clear and sets a sticky flag.

Top module: `tmr_bank_regif`

## Requirements
- R1: After a synchronous active-low reset, all channel control outputs, all start, stop and update pulses, `pulse_err`, `bus_rdata` and `bus_err` are zero.
- R2: Aligned offsets 0x00 to 0x2C address channel indices 0 to 2. The channel index is offset bits [5:4] and the register index is offset bits [3:2]. A written word reads back unchanged.
- R3: Aligned offsets 0x40 to 0x8C address channel index (offset >> 4) - 1, which gives indices 3 to 7. The register index is offset bits [3:2].
- R4: Offset 0x30 is the shared control word. Channel i owns bits [4i+3:4i]: bit 0 enable, bit 1 external clock select, bit 2 overflow-interrupt enable, bit 3 pulse mode. A read returns the bits currently applied.
- R5: Offset 0x34 stores a 32-bit word that reads back unchanged and drives no channel output.
- R6: An access to any other offset, or with offset bits [1:0] not zero, is rejected. A read returns zero, `bus_err` is 1 in the cycle after the access, and a write changes no register.
- R7: When a control write clears the enable of a running channel, its enable output falls and `chan_stop` pulses in the cycle after the write. This is the same cycle in which its other three bits take their new values.
- R8: When a control write sets the enable of a stopped channel, its other bits take effect in the cycle after the write. Its enable output rises and `chan_start` pulses one cycle later.
- R9: A control write that leaves a channel's bits unchanged produces no start, stop or update pulse for that channel. `chan_cfg_upd` pulses only for channels whose non-enable bits change.
- R10: Pulse mode takes effect only on channel indices 4 to 7. Writing a 1 to the pulse bit of indices 0 to 3 leaves that bit 0 and sets `pulse_err`, which stays set until reset.
- R11: A read returns its data on `bus_rdata` in the cycle after the read strobe. During a channel access, exactly one bit of `ch_wr_stb` or `ch_rd_stb` is high in that same cycle, and `ch_reg_idx` carries the register index.
- R12: A control write in the cycle right after a control write replaces any pending enable. A pending channel that the second write leaves disabled never starts and gives no stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | Rejected access, the cycle after the strobe |
| ch_wr_stb | output | 8 | Per-channel register write strobe |
| ch_rd_stb | output | 8 | Per-channel register read strobe |
| ch_reg_idx | output | 2 | Register index within the channel |
| ch_wdata | output | 32 | Write data to the channels |
| chan_en | output | 8 | Applied enable per channel |
| chan_extclk | output | 8 | Applied external clock select per channel |
| chan_ovf_ie | output | 8 | Applied overflow-interrupt enable per channel |
| chan_pulse_en | output | 8 | Applied pulse mode per channel |
| chan_start | output | 8 | One-cycle start pulse per channel |
| chan_stop | output | 8 | One-cycle stop pulse per channel |
| chan_cfg_upd | output | 8 | One-cycle configuration-change pulse per channel |
| pulse_err | output | 1 | Sticky flag for pulse mode asked on a low channel |

## Verification
The hardest case to reach from the ports is a control write that arrives while an enable from the previous write is still pending. Only a write on the very next clock hits that window. The bench produces it by holding the write strobe for two back-to-back cycles with different data. It then watches the start and stop pulses over the following cycles. The map is covered by a sweep over every aligned offset in the low 512 bytes plus the top word. A misaligned write is then made into live registers and the map is read again, so that a write which should have been ignored would show up as changed data.

// File: rtl/tmr_regif_pkg.sv
// Package: shared types and control-field positions for the timer bank
// register front end.
// Assumes four control bits per channel in a fixed order within each nibble.
package tmr_regif_pkg;

    localparam int CTRL_BITS = 4;
    localparam int BIT_EN    = 0;
    localparam int BIT_EXT   = 1;
    localparam int BIT_OVF   = 2;
    localparam int BIT_PLS   = 3;
    localparam int REGS_PER_CH = 4;

    typedef enum logic [2:0] {
        ACC_CHAN  = 3'd0,
        ACC_CTRL  = 3'd1,
        ACC_CTRL2 = 3'd2,
        ACC_BAD   = 3'd3
    } acc_kind_e;

endpackage

// File: rtl/tmr_addr_dec.sv
// Module: tmr_addr_dec
// Purpose: turns a byte offset into an access kind, a channel index and a
// register index.
// Layout: the low channels come first, then the control word and the spare
// word, then the high channels, which start one 16-byte block above the
// control word.
// Assumes: NUM_CH > LO_CH >= 2 and 16 bytes per channel.
module tmr_addr_dec
    import tmr_regif_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 8,
    parameter int LO_CH  = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [CH_W-1:0]   ch_idx,
    output logic [1:0]        reg_idx
);

    localparam int LO_END    = (LO_CH - 1) * 16;
    localparam int CTRL_OFF  = LO_END;
    localparam int CTRL2_OFF = LO_END + 4;
    localparam int HI_BASE   = LO_CH * 16;
    localparam int HI_END    = (NUM_CH + 1) * 16;

    logic [ADDR_W-1:0] blk;
    logic [ADDR_W-1:0] blk_m1;

    // Block number of the offset, and the same minus one for the high region.
    always_comb begin
        blk    = addr >> 4;
        blk_m1 = blk - ADDR_W'(1);
    end

    // Classify the offset and select the channel index.
    always_comb begin
        kind    = ACC_BAD;
        ch_idx  = '0;
        reg_idx = addr[3:2];
        if (addr[1:0] != 2'b00) begin
            kind = ACC_BAD;
        end else if (addr < ADDR_W'(LO_END)) begin
            kind   = ACC_CHAN;
            ch_idx = blk[CH_W-1:0];
        end else if (addr == ADDR_W'(CTRL_OFF)) begin
            kind = ACC_CTRL;
        end else if (addr == ADDR_W'(CTRL2_OFF)) begin
            kind = ACC_CTRL2;
        end else if (addr >= ADDR_W'(HI_BASE) && addr < ADDR_W'(HI_END)) begin
            kind   = ACC_CHAN;
            ch_idx = blk_m1[CH_W-1:0];
        end
    end

endmodule

// File: rtl/tmr_ctrl_seq.sv
// Module: tmr_ctrl_seq
// Purpose: holds the applied control bits of every channel and carries out
// a control write in two steps. The first cycle applies disables and the
// configuration bits. The second cycle applies enables.
// Assumes: ctl_wr is a single-cycle strobe. A new write replaces any
// pending enable.
module tmr_ctrl_seq
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int LO_CH  = 4,
    localparam int CTRL_W = NUM_CH * CTRL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] ext_o,
    output logic [NUM_CH-1:0] ovf_o,
    output logic [NUM_CH-1:0] pls_o,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] stop_o,
    output logic [NUM_CH-1:0] upd_o,
    output logic              pulse_err_o
);

    logic [NUM_CH-1:0] en_q, ext_q, ovf_q, pls_q, pend_q;
    logic [NUM_CH-1:0] start_q, stop_q, upd_q;
    logic [NUM_CH-1:0] en_d, ext_d, ovf_d, pls_d, pend_d;
    logic [NUM_CH-1:0] start_d, stop_d, upd_d;
    logic              err_q, err_d;
    logic              lo_pls_req;

    // Detect a pulse-mode request on a channel that cannot pulse.
    always_comb begin
        lo_pls_req = 1'b0;
        for (int i = 0; i < LO_CH; i++) begin
            lo_pls_req = lo_pls_req | ctl_wdata[i*CTRL_BITS + BIT_PLS];
        end
    end

    // Next state: step one on a write, otherwise commit pending enables.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            logic [CTRL_BITS-1:0] nw;
            logic                 pls_ok;
            nw     = ctl_wdata[i*CTRL_BITS +: CTRL_BITS];
            pls_ok = (i >= LO_CH) ? nw[BIT_PLS] : 1'b0;
            if (ctl_wr) begin
                en_d[i]    = en_q[i] & nw[BIT_EN];
                pend_d[i]  = nw[BIT_EN] & ~en_q[i];
                stop_d[i]  = en_q[i] & ~nw[BIT_EN];
                start_d[i] = 1'b0;
                ext_d[i]   = nw[BIT_EXT];
                ovf_d[i]   = nw[BIT_OVF];
                pls_d[i]   = pls_ok;
                upd_d[i]   = (ext_q[i] != nw[BIT_EXT]) | (ovf_q[i] != nw[BIT_OVF])
                           | (pls_q[i] != pls_ok);
            end else begin
                en_d[i]    = en_q[i] | pend_q[i];
                pend_d[i]  = 1'b0;
                stop_d[i]  = 1'b0;
                start_d[i] = pend_q[i] & ~en_q[i];
                ext_d[i]   = ext_q[i];
                ovf_d[i]   = ovf_q[i];
                pls_d[i]   = pls_q[i];
                upd_d[i]   = 1'b0;
            end
        end
        err_d = err_q | (ctl_wr & lo_pls_req);
    end

    // State registers for applied bits, pending enables and action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            ext_q   <= '0;
            ovf_q   <= '0;
            pls_q   <= '0;
            pend_q  <= '0;
            start_q <= '0;
            stop_q  <= '0;
            upd_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            en_q    <= en_d;
            ext_q   <= ext_d;
            ovf_q   <= ovf_d;
            pls_q   <= pls_d;
            pend_q  <= pend_d;
            start_q <= start_d;
            stop_q  <= stop_d;
            upd_q   <= upd_d;
            err_q   <= err_d;
        end
    end

    // Pack the applied bits back into the control-word layout.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ctrl_rd[i*CTRL_BITS + BIT_EN]  = en_q[i];
            ctrl_rd[i*CTRL_BITS + BIT_EXT] = ext_q[i];
            ctrl_rd[i*CTRL_BITS + BIT_OVF] = ovf_q[i];
            ctrl_rd[i*CTRL_BITS + BIT_PLS] = pls_q[i];
        end
    end

    assign en_o        = en_q;
    assign ext_o       = ext_q;
    assign ovf_o       = ovf_q;
    assign pls_o       = pls_q;
    assign start_o     = start_q;
    assign stop_o      = stop_q;
    assign upd_o       = upd_q;
    assign pulse_err_o = err_q;

    // R10
    pulse_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8
        en_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_q[g]) |-> $past(pend_q[g]));
        // R7
        dis_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_q[g]) |-> $past(ctl_wr));
        // R12
        pend_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_wr && pend_q[g] && !ctl_wdata[g*CTRL_BITS + BIT_EN]
            |=> !en_q[g] && !start_q[g]);
        // R9
        same_bits_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_wr && (ctl_wdata[g*CTRL_BITS +: CTRL_BITS] == ctrl_rd[g*CTRL_BITS +: CTRL_BITS])
            |=> !start_q[g] && !stop_q[g] && !upd_q[g]);
    end

endmodule

// File: rtl/tmr_chan_stub.sv
// Module: tmr_chan_stub
// Purpose: stand-in for one counting channel. It keeps the channel's
// register words so that the map can be written and read back.
// Assumes: one write strobe per access and a combinational read port.
module tmr_chan_stub
    import tmr_regif_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(REGS_PER_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [REGS_PER_CH];

    // Store a word into the addressed register slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REGS_PER_CH; r++) regs_q[r] <= '0;
        end else if (wr_stb) begin
            regs_q[reg_idx] <= wdata;
        end
    end

    // Present the addressed register for reading.
    assign rd_data = regs_q[reg_idx];

endmodule

// File: rtl/tmr_bank_regif.sv
// Module: tmr_bank_regif
// Purpose: top of the timer bank register front end. It decodes bus
// accesses, drives the channel strobes, holds the spare control word,
// hosts the channel stubs and returns registered read data and error.
// Assumes: bus_wr and bus_rd are never high together. DATA_W is at least
// NUM_CH*4.
module tmr_bank_regif
    import tmr_regif_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 8,
    parameter int LO_CH  = 4,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int CTRL_W = NUM_CH * CTRL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [NUM_CH-1:0] ch_wr_stb,
    output logic [NUM_CH-1:0] ch_rd_stb,
    output logic [1:0]        ch_reg_idx,
    output logic [DATA_W-1:0] ch_wdata,
    output logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] chan_extclk,
    output logic [NUM_CH-1:0] chan_ovf_ie,
    output logic [NUM_CH-1:0] chan_pulse_en,
    output logic [NUM_CH-1:0] chan_start,
    output logic [NUM_CH-1:0] chan_stop,
    output logic [NUM_CH-1:0] chan_cfg_upd,
    output logic              pulse_err
);

    acc_kind_e         kind;
    logic [CH_W-1:0]   ch_idx;
    logic [1:0]        reg_idx;
    logic              ctl_wr;
    logic [CTRL_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] ctrl2_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic [DATA_W-1:0] stub_rd [NUM_CH];

    tmr_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .LO_CH(LO_CH)) dec_i (
        .addr    (bus_addr),
        .kind    (kind),
        .ch_idx  (ch_idx),
        .reg_idx (reg_idx)
    );

    // Control write strobe.
    assign ctl_wr = bus_wr && (kind == ACC_CTRL);

    tmr_ctrl_seq #(.NUM_CH(NUM_CH), .LO_CH(LO_CH)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (bus_wdata[CTRL_W-1:0]),
        .ctrl_rd     (ctrl_rd),
        .en_o        (chan_en),
        .ext_o       (chan_extclk),
        .ovf_o       (chan_ovf_ie),
        .pls_o       (chan_pulse_en),
        .start_o     (chan_start),
        .stop_o      (chan_stop),
        .upd_o       (chan_cfg_upd),
        .pulse_err_o (pulse_err)
    );

    // One strobe pair and one stub per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_wr_stb[g] = bus_wr && (kind == ACC_CHAN) && (ch_idx == CH_W'(g));
        assign ch_rd_stb[g] = bus_rd && (kind == ACC_CHAN) && (ch_idx == CH_W'(g));
        tmr_chan_stub #(.DATA_W(DATA_W)) stub_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (ch_wr_stb[g]),
            .reg_idx (reg_idx),
            .wdata   (bus_wdata),
            .rd_data (stub_rd[g])
        );
    end

    assign ch_reg_idx = reg_idx;
    assign ch_wdata   = bus_wdata;

    // Spare control word: stored and read back only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ctrl2_q <= '0;
        else if (bus_wr && (kind == ACC_CTRL2))     ctrl2_q <= bus_wdata;
    end

    // Select read data by access kind. A rejected offset reads as zero.
    always_comb begin
        case (kind)
            ACC_CHAN:  rd_val = stub_rd[ch_idx];
            ACC_CTRL:  rd_val = DATA_W'(ctrl_rd);
            ACC_CTRL2: rd_val = ctrl2_q;
            default:   rd_val = '0;
        endcase
    end

    // Register read data and the error flag for the cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= bus_rd ? rd_val : '0;
            err_q   <= (bus_wr || bus_rd) && (kind == ACC_BAD);
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    // R11
    wr_stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr_stb) && $onehot0(ch_rd_stb));
    // R6
    misalign_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr[1:0] != 2'b00) |-> (ch_wr_stb == '0) && !ctl_wr);
    // R6
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr[1:0] != 2'b00) |=> bus_err && (bus_rdata == '0));

endmodule

// File: tb/tmr_bank_regif_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  ch_wr_stb, ch_rd_stb;
    logic [1:0]  ch_reg_idx;
    logic [31:0] ch_wdata;
    logic [7:0]  chan_en, chan_extclk, chan_ovf_ie, chan_pulse_en;
    logic [7:0]  chan_start, chan_stop, chan_cfg_upd;
    logic        pulse_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [8][4];
    logic [31:0] mdl_ctrl2 = '0;

    always #4 clk = ~clk;

    tmr_bank_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .ch_wr_stb(ch_wr_stb), .ch_rd_stb(ch_rd_stb), .ch_reg_idx(ch_reg_idx),
        .ch_wdata(ch_wdata), .chan_en(chan_en), .chan_extclk(chan_extclk),
        .chan_ovf_ie(chan_ovf_ie), .chan_pulse_en(chan_pulse_en),
        .chan_start(chan_start), .chan_stop(chan_stop), .chan_cfg_upd(chan_cfg_upd),
        .pulse_err(pulse_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    // Channel index for an offset, or -1 for the control words and rejected offsets.
    function automatic int map_ch(input int off);
        if (off % 4 != 0) return -1;
        if (off < 'h30) return off >> 4;
        if (off >= 'h40 && off < 'h90) return (off >> 4) - 1;
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(input int off);
        int c;
        c = map_ch(off);
        if (c >= 0) return mdl[c][(off >> 2) & 3];
        if (off == 'h34) return mdl_ctrl2;
        return 32'h0;
    endfunction

    function automatic logic exp_bad(input int off);
        return (map_ch(off) < 0) && (off != 'h30) && (off != 'h34);
    endfunction

    task automatic sweep_read(input string req);
        logic [31:0] d;
        logic e;
        for (int off = 0; off < 'h200; off += 4) begin
            bus_read(off[11:0], d, e);
            if (off != 'h30) chk(req, d, exp_read(off));
            chk("R6", {31'b0, e}, {31'b0, exp_bad(off)});
        end
        bus_read(12'hFFC, d, e);
        chk("R6", d, 32'h0);
        chk("R6", {31'b0, e}, 32'h1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic e;
        for (int c = 0; c < 8; c++) for (int r = 0; r < 4; r++) mdl[c][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", {chan_en, chan_extclk, chan_ovf_ie, chan_pulse_en}, 32'h0);
        chk("R1", {chan_start, chan_stop, chan_cfg_upd, 7'b0, pulse_err}, 32'h0);
        chk("R1", bus_rdata, 32'h0);
        chk("R1", {31'b0, bus_err}, 32'h0);

        // R11: combinational strobe on a high-channel write (offset 0x84 -> index 7, reg 1)
        @(negedge clk);
        bus_addr = 12'h084; bus_wdata = 32'h1234_5678; bus_wr = 1'b1;
        #1;
        chk("R11", {24'b0, ch_wr_stb}, 32'h80);
        chk("R11", {30'b0, ch_reg_idx}, 32'h1);
        chk("R11", ch_wdata, 32'h1234_5678);
        mdl[7][1] = 32'h1234_5678;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = 12'h010; bus_rd = 1'b1;
        #1;
        chk("R11", {24'b0, ch_rd_stb}, 32'h02);
        @(negedge clk);
        bus_rd = 1'b0;

        // R2 R3 R5 R6: write every offset except the control word, then read all back
        for (int off = 0; off < 'h200; off += 4) begin
            if (off == 'h30) continue;
            bus_write(off[11:0], 32'h5A00_0000 | (off << 4) | 32'h3);
            if (map_ch(off) >= 0) mdl[map_ch(off)][(off >> 2) & 3] = 32'h5A00_0000 | (off << 4) | 32'h3;
            if (off == 'h34) mdl_ctrl2 = 32'h5A00_0000 | (off << 4) | 32'h3;
        end
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        sweep_read("R2 R3");
        // R5: the spare word drives nothing
        chk("R5", {chan_en, chan_extclk, chan_ovf_ie, chan_pulse_en}, 32'h0);

        // R6: misaligned writes into live registers leave them unchanged
        bus_write(12'h001, 32'hFFFF_FFFF);
        bus_write(12'h016, 32'hFFFF_FFFF);
        bus_write(12'h087, 32'hFFFF_FFFF);
        bus_write(12'h032, 32'h1111_1111);
        chk("R6", {24'b0, chan_en}, 32'h0);
        sweep_read("R6");
        bus_read(12'h005, d, e);
        chk("R6", d, 32'h0);
        chk("R6", {31'b0, e}, 32'h1);

        // R8 R4: enable channel 0 with external clock and overflow interrupt
        bus_write(12'h030, 32'h0000_0007);
        chk("R8", {24'b0, chan_en}, 32'h00);
        chk("R8", {24'b0, chan_extclk}, 32'h01);
        chk("R8", {24'b0, chan_ovf_ie}, 32'h01);
        chk("R9", {24'b0, chan_cfg_upd}, 32'h01);
        chk("R8", {24'b0, chan_start}, 32'h00);
        @(negedge clk);
        chk("R8", {24'b0, chan_en}, 32'h01);
        chk("R8", {24'b0, chan_start}, 32'h01);
        @(negedge clk);
        chk("R8", {24'b0, chan_start}, 32'h00);
        bus_read(12'h030, d, e);
        chk("R4", d, 32'h0000_0007);

        // R9: same value again gives no pulses
        bus_write(12'h030, 32'h0000_0007);
        chk("R9", {chan_start, chan_stop, chan_cfg_upd}, 24'h0);
        @(negedge clk);
        chk("R9", {chan_start, chan_stop, chan_cfg_upd}, 24'h0);
        chk("R9", {24'b0, chan_en}, 32'h01);

        // R7: disable with configuration change in the same cycle
        bus_write(12'h030, 32'h0000_0000);
        chk("R7", {24'b0, chan_en}, 32'h00);
        chk("R7", {24'b0, chan_stop}, 32'h01);
        chk("R7", {24'b0, chan_extclk}, 32'h00);
        chk("R7", {24'b0, chan_cfg_upd}, 32'h01);
        @(negedge clk);
        chk("R7", {24'b0, chan_stop}, 32'h00);

        // R8 R7 R4: all channels on, then every odd channel off
        bus_write(12'h030, 32'h1111_1111);
        chk("R8", {24'b0, chan_en}, 32'h00);
        @(negedge clk);
        chk("R8", {24'b0, chan_start}, 32'hFF);
        chk("R8", {24'b0, chan_en}, 32'hFF);
        bus_write(12'h030, 32'h0101_0101);
        chk("R7", {24'b0, chan_stop}, 32'hAA);
        chk("R7", {24'b0, chan_en}, 32'h55);
        chk("R9", {24'b0, chan_cfg_upd}, 32'h00);
        bus_read(12'h030, d, e);
        chk("R4", d, 32'h0101_0101);
        bus_write(12'h030, 32'h0000_0000);

        // R12: back-to-back control writes cancel a pending enable
        @(negedge clk);
        bus_addr = 12'h030; bus_wdata = 32'h0000_0010; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 32'h0000_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R12", {24'b0, chan_en}, 32'h00);
        chk("R12", {chan_start, chan_stop}, 16'h0);
        @(negedge clk);
        chk("R12", {24'b0, chan_en}, 32'h00);
        chk("R12", {chan_start, chan_stop}, 16'h0);

        // R10: pulse mode on index 4 is honoured without error
        bus_write(12'h030, 32'h0008_0000);
        chk("R10", {24'b0, chan_pulse_en}, 32'h10);
        chk("R10", {31'b0, pulse_err}, 32'h0);
        // R10: pulse mode on index 0 is refused and flagged
        bus_write(12'h030, 32'h0008_0008);
        chk("R10", {24'b0, chan_pulse_en}, 32'h10);
        chk("R10", {31'b0, pulse_err}, 32'h1);
        bus_read(12'h030, d, e);
        chk("R10", d, 32'h0008_0000);
        bus_write(12'h030, 32'h0000_0000);
        chk("R10", {31'b0, pulse_err}, 32'h1);
        chk("R10", {24'b0, chan_pulse_en}, 32'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule